// File: doc/BRIEF.md
# Area-Decoded External Bus Controller

This block connects an internal request/acknowledge port to an external asynchronous memory bus that serves eight memory areas. Bits 28 to 26 of the 32-bit physical address pick the area. Bits 31 to 29 are not decoded, so each area also answers at its base plus any multiple of 0x20000000. During a bus cycle the controller pulls that area's chip select low. It then drives either an active-low read strobe, which a device can use as its output enable, or four active-low byte write strobes.

Each area has two configuration fields. A 2-bit field gives the device's data bus width. A 3-bit field gives the number of inserted wait cycles. Area 4 decodes its wait field into a longer range than the other areas. An access wider than the device port is split into consecutive bus cycles at ascending addresses. The most significant data goes out first, which keeps the big-endian byte order. Internal write data and read data are right-justified.

Top module: `xbus_area_ctrl`

## Requirements
- R1: The area index is address bits 28:26. While a request to area i is in progress, only `ext_cs_n[i]` is low. Address bits 31:29 have no effect on decoding or timing.
- R2: Out of reset and while idle, every chip select, `ext_rd_n` and every `ext_we_n` bit is high, and `ack` is low.
- R3: At most one chip select is low at a time. A strobe is only active while a chip select is low. The read strobe and the write strobes are never active together.
- R4: Each bus cycle (beat) has three parts. It starts with one setup cycle in which only the chip select is active. Then come N+1 strobe cycles, where N is the area's wait count. It ends with one hold cycle in which only the chip select is active. The chip select stays low across all beats of a request and goes high in the cycle after `ack`.
- R5: `ack` is high for exactly one cycle, the hold cycle of the last beat. On a read, `rdata` holds the assembled data in that cycle, right-justified with zeros above.
- R6: In every area except area 4, the wait count is bits 1:0 of the area's wait field (0 to 3). Bit 2 is ignored.
- R7: For area 4, wait field values 0 to 4 give 0 to 4 wait cycles, 5 gives 6, 6 gives 8 and 7 gives 10.
- R8: Request size and area port width share one 2-bit encoding: 01 is byte, 10 is word, 11 is longword, and 00 is treated as longword.
- R9: On a 32-bit port, lane 3 is data bits 31:24 with `ext_we_n[3]`, and lane 0 is bits 7:0 with `ext_we_n[0]`. A byte at offset o uses lane 3-o. A word at offset 0 uses lanes 3:2, and a word at offset 2 uses lanes 1:0.
- R10: An 8-bit port uses lane 0. A 16-bit port uses lanes 1:0, with the byte at the even address on lane 1. An access wider than its port is split into beats at ascending addresses, with the most significant data in the first beat.
- R11: `ext_addr` is the low 26 bits of the current beat's byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req | input | 1 | Access request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Physical byte address |
| req_size | input | 2 | Access size (01 byte, 10 word, 11/00 longword) |
| req_wdata | input | 32 | Right-justified write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Right-justified read data, valid with `ack` |
| cfg_size | input | 16 | Per-area port width, 2 bits per area, area i at [2i+1:2i] |
| cfg_wait | input | 24 | Per-area wait field, 3 bits per area, area i at [3i+2:3i] |
| ext_cs_n | output | 8 | Active-low chip selects, one per area |
| ext_rd_n | output | 1 | Active-low read strobe / output enable |
| ext_we_n | output | 4 | Active-low byte write strobes, bit k for lane k |
| ext_addr | output | 26 | Byte address within the area |
| ext_dout | output | 32 | Write data lanes |
| ext_din | input | 32 | Read data lanes |

## Verification
The assertions take three things as given. First, `req` and its attributes stay stable from the request until the `ack` cycle. Second, `req` drops in that cycle when no further access follows. Third, the address is aligned to the access size, so lane arithmetic never wraps past the port. The stimulus keeps within these by clearing the address bits below the access size and by holding every request field until it observes `ack`. Configuration is changed only while the bus is idle. The bench still randomizes the ignored upper address bits and the ignored wait bit, so it exercises the shadow spaces and the per-area wait decoding.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } xbus_phase_e;

  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  // Shared size code: 01 byte, 10 word, 11 and 00 longword.
  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Extended wait decode: 0..4 linear, then 6, 8, 10.
  function automatic logic [3:0] long_wait_decode(input logic [2:0] code);
    if (code <= 3'd4) return {1'b0, code};
    else              return {code - 3'd5, 1'b0} + 4'd6;
  endfunction

  // Number of beats minus one for a given access and port width.
  function automatic logic [2:0] beats_minus1(input logic [2:0] acc,
                                              input logic [2:0] port);
    if (acc <= port) return 3'd0;
    case (port)
      3'd1:    return acc - 3'd1;
      3'd2:    return (acc >> 1) - 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] min_bytes(input logic [2:0] a,
                                           input logic [2:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/xbus_area_dec.sv
module xbus_area_dec
  import xbus_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int AREA_W         = 3,
  parameter int AREA_LSB       = 26,
  parameter int WFIELD_W       = 3,
  parameter int WAIT_W         = 4,
  parameter int LONG_WAIT_AREA = 4,
  localparam int N_AREA        = 1 << AREA_W
)(
  input  logic [ADDR_W-1:0]          addr,
  input  logic [N_AREA*2-1:0]        cfg_size,
  input  logic [N_AREA*WFIELD_W-1:0] cfg_wait,
  output logic [AREA_W-1:0]          area,
  output logic [2:0]                 port_bytes,
  output logic [WAIT_W-1:0]          wait_cycles
);

  logic [WAIT_W-1:0] wait_tab [N_AREA];
  logic [2:0]        port_tab [N_AREA];

  // Bits above the area field are not looked at: shadow spaces.
  assign area = addr[AREA_LSB +: AREA_W];

  for (genvar i = 0; i < N_AREA; i++) begin : g_area
    assign port_tab[i] = size_to_bytes(cfg_size[i*2 +: 2]);
    if (i == LONG_WAIT_AREA) begin : g_long
      assign wait_tab[i] = WAIT_W'(long_wait_decode(cfg_wait[i*WFIELD_W +: 3]));
    end else begin : g_short
      assign wait_tab[i] = WAIT_W'(cfg_wait[i*WFIELD_W +: 2]);
    end
  end

  assign wait_cycles = wait_tab[area];
  assign port_bytes  = port_tab[area];

endmodule

// File: rtl/xbus_lane_map.sv
module xbus_lane_map #(
  parameter int DATA_W  = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LOFF_W = $clog2(LANES)
)(
  input  logic [LOFF_W-1:0] beat_off,
  input  logic [2:0]        unit_bytes,
  input  logic [2:0]        port_bytes,
  input  logic [DATA_W-1:0] chunk_w,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [LANES-1:0]  lane_mask,
  output logic [DATA_W-1:0] chunk_r
);

  logic [2:0]        off_in_port;
  logic [2:0]        lane_lo;
  logic [5:0]        lane_sh;
  logic [5:0]        unit_sh;
  logic [DATA_W-1:0] unit_mask;
  logic [LANES:0]    unit_ones;

  // Big-endian placement: lowest address sits in the highest lane of the port.
  assign off_in_port = 3'(beat_off) & (port_bytes - 3'd1);
  assign lane_lo     = port_bytes - off_in_port - unit_bytes;
  assign lane_sh     = {lane_lo, 3'b000};
  assign unit_sh     = {unit_bytes, 3'b000};

  assign unit_mask = (unit_bytes >= 3'(LANES)) ? '1
                   : ((DATA_W'(1) << unit_sh) - DATA_W'(1));
  assign unit_ones = ((LANES+1)'(1) << unit_bytes) - (LANES+1)'(1);

  assign lane_mask = LANES'(unit_ones) << lane_lo;
  assign bus_out   = (chunk_w & unit_mask) << lane_sh;
  assign chunk_r   = (bus_in >> lane_sh) & unit_mask;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int AREA_W   = 3,
  parameter int AREA_LSB = 26,
  parameter int WAIT_W   = 4,
  localparam int N_AREA  = 1 << AREA_W,
  localparam int LANES   = DATA_W / 8,
  localparam int LOFF_W  = $clog2(LANES)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [AREA_W-1:0]   dec_area,
  input  logic [2:0]          dec_port_bytes,
  input  logic [WAIT_W-1:0]   dec_wait,
  output logic                ack,
  output logic [DATA_W-1:0]   rdata,
  output logic [N_AREA-1:0]   cs_n,
  output logic                rd_n,
  output logic [LANES-1:0]    we_n,
  output logic [AREA_LSB-1:0] beat_addr,
  output logic [LOFF_W-1:0]   beat_off,
  output logic [2:0]          unit_bytes,
  output logic [2:0]          port_bytes,
  output logic [DATA_W-1:0]   chunk_w,
  input  logic [LANES-1:0]    lane_mask,
  input  logic [DATA_W-1:0]   chunk_r
);

  xbus_phase_e         phase_q, phase_d;
  logic [AREA_W-1:0]   area_q;
  logic                we_q;
  logic [AREA_LSB-1:0] addr_q, addr_d;
  logic [2:0]          beats_q, beats_d;
  logic [WAIT_W-1:0]   wait_q;
  logic [WAIT_W-1:0]   cnt_q, cnt_d;
  logic [2:0]          unit_q, port_q;
  logic [DATA_W-1:0]   wsh_q, wsh_d;
  logic [DATA_W-1:0]   racc_q, racc_d;

  logic [2:0]          acc_bytes;
  logic [5:0]          unit_sh;
  logic                xfer_ld;
  logic                beat_adv;
  logic                rd_cap;
  logic                cnt_en;
  logic                last_strobe;
  logic                strobe_on;

  assign acc_bytes   = size_to_bytes(req_size);
  assign unit_sh     = {unit_q, 3'b000};
  assign last_strobe = (cnt_q == wait_q);
  assign strobe_on   = (phase_q == PH_STROBE);

  // ---------------- next-state logic ----------------
  always_comb begin
    phase_d  = phase_q;
    addr_d   = addr_q;
    beats_d  = beats_q;
    cnt_d    = cnt_q;
    wsh_d    = wsh_q;
    racc_d   = racc_q;
    xfer_ld  = 1'b0;
    beat_adv = 1'b0;
    rd_cap   = 1'b0;
    cnt_en   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req) begin
          xfer_ld = 1'b1;
          phase_d = PH_SETUP;
          addr_d  = req_addr[AREA_LSB-1:0];
          beats_d = beats_minus1(acc_bytes, dec_port_bytes);
          // Left-align so that each beat takes the top unit of bytes.
          wsh_d   = req_wdata << {3'(LANES) - acc_bytes, 3'b000};
          racc_d  = '0;
        end
      end
      PH_SETUP: begin
        cnt_en  = 1'b1;
        cnt_d   = '0;
        phase_d = PH_STROBE;
      end
      PH_STROBE: begin
        if (last_strobe) begin
          phase_d = PH_HOLD;
          rd_cap  = ~we_q;
          racc_d  = (racc_q << unit_sh) | chunk_r;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + WAIT_W'(1);
        end
      end
      PH_HOLD: begin
        if (beats_q == 3'd0) begin
          phase_d = PH_IDLE;
        end else begin
          beat_adv = 1'b1;
          phase_d  = PH_SETUP;
          beats_d  = beats_q - 3'd1;
          addr_d   = addr_q + AREA_LSB'(unit_q);
          wsh_d    = wsh_q << unit_sh;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      area_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      beats_q <= '0;
      wait_q  <= '0;
      cnt_q   <= '0;
      unit_q  <= 3'd1;
      port_q  <= 3'd1;
      wsh_q   <= '0;
      racc_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (xfer_ld) begin
        area_q <= dec_area;
        we_q   <= req_we;
        wait_q <= dec_wait;
        unit_q <= min_bytes(acc_bytes, dec_port_bytes);
        port_q <= dec_port_bytes;
      end
      if (xfer_ld || beat_adv) begin
        addr_q  <= addr_d;
        beats_q <= beats_d;
        wsh_q   <= wsh_d;
      end
      if (cnt_en) cnt_q <= cnt_d;
      if (xfer_ld || rd_cap) racc_q <= racc_d;
    end
  end

  // ---------------- outputs ----------------
  assign cs_n       = (phase_q == PH_IDLE) ? '1 : ~(N_AREA'(1) << area_q);
  assign rd_n       = ~(strobe_on & ~we_q);
  assign we_n       = (strobe_on & we_q) ? ~lane_mask : '1;
  assign ack        = (phase_q == PH_HOLD) && (beats_q == 3'd0);
  assign rdata      = racc_q;
  assign beat_addr  = addr_q;
  assign beat_off   = addr_q[LOFF_W-1:0];
  assign unit_bytes = unit_q;
  assign port_bytes = port_q;
  assign chunk_w    = wsh_q >> (DATA_W - int'(unit_sh));

  // ---------------- assertions ----------------
  logic cs_any, stb_any;
  assign cs_any  = ~(&cs_n);
  assign stb_any = ~rd_n | ~(&we_n);

  AST_ONE_CHIP_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R3
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    stb_any |-> cs_any); // R3
  AST_RD_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(~rd_n && ~(&we_n))); // R3
  AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_any) |-> !stb_any); // R4
  AST_STROBE_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_any |=> cs_any); // R4
  AST_CS_HELD_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_any && !ack) |=> $stable(cs_n)); // R4
  AST_ACK_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !cs_any); // R4
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R5
  AST_ACK_ON_QUIET_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cs_any && !stb_any)); // R5
  AST_WAIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> (cnt_q <= WAIT_W'(10))); // R7
  AST_LANES_IN_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> ((LANES+1)'(lane_mask) < ((LANES+1)'(1) << port_q))); // R10

endmodule

// File: rtl/xbus_area_ctrl.sv
module xbus_area_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int AREA_W         = 3,
  parameter int AREA_LSB       = 26,
  parameter int WFIELD_W       = 3,
  parameter int WAIT_W         = 4,
  parameter int LONG_WAIT_AREA = 4,
  localparam int N_AREA        = 1 << AREA_W,
  localparam int LANES         = DATA_W / 8,
  localparam int LOFF_W        = $clog2(LANES)
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic                       req_we,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [1:0]                 req_size,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       ack,
  output logic [DATA_W-1:0]          rdata,
  input  logic [N_AREA*2-1:0]        cfg_size,
  input  logic [N_AREA*WFIELD_W-1:0] cfg_wait,
  output logic [N_AREA-1:0]          ext_cs_n,
  output logic                       ext_rd_n,
  output logic [LANES-1:0]           ext_we_n,
  output logic [AREA_LSB-1:0]        ext_addr,
  output logic [DATA_W-1:0]          ext_dout,
  input  logic [DATA_W-1:0]          ext_din
);

  logic [AREA_W-1:0] dec_area;
  logic [2:0]        dec_port_bytes;
  logic [WAIT_W-1:0] dec_wait;
  logic [LOFF_W-1:0] beat_off;
  logic [2:0]        unit_bytes;
  logic [2:0]        port_bytes;
  logic [DATA_W-1:0] chunk_w;
  logic [DATA_W-1:0] chunk_r;
  logic [LANES-1:0]  lane_mask;

  xbus_area_dec #(
    .ADDR_W(ADDR_W), .AREA_W(AREA_W), .AREA_LSB(AREA_LSB),
    .WFIELD_W(WFIELD_W), .WAIT_W(WAIT_W), .LONG_WAIT_AREA(LONG_WAIT_AREA)
  ) u_dec (
    .addr        (req_addr),
    .cfg_size    (cfg_size),
    .cfg_wait    (cfg_wait),
    .area        (dec_area),
    .port_bytes  (dec_port_bytes),
    .wait_cycles (dec_wait)
  );

  xbus_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AREA_W(AREA_W),
    .AREA_LSB(AREA_LSB), .WAIT_W(WAIT_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req            (req),
    .req_we         (req_we),
    .req_addr       (req_addr),
    .req_size       (req_size),
    .req_wdata      (req_wdata),
    .dec_area       (dec_area),
    .dec_port_bytes (dec_port_bytes),
    .dec_wait       (dec_wait),
    .ack            (ack),
    .rdata          (rdata),
    .cs_n           (ext_cs_n),
    .rd_n           (ext_rd_n),
    .we_n           (ext_we_n),
    .beat_addr      (ext_addr),
    .beat_off       (beat_off),
    .unit_bytes     (unit_bytes),
    .port_bytes     (port_bytes),
    .chunk_w        (chunk_w),
    .lane_mask      (lane_mask),
    .chunk_r        (chunk_r)
  );

  xbus_lane_map #(.DATA_W(DATA_W)) u_lane (
    .beat_off   (beat_off),
    .unit_bytes (unit_bytes),
    .port_bytes (port_bytes),
    .chunk_w    (chunk_w),
    .bus_in     (ext_din),
    .bus_out    (ext_dout),
    .lane_mask  (lane_mask),
    .chunk_r    (chunk_r)
  );

endmodule

// File: tb/xbus_area_ctrl_bench.sv
module xbus_area_ctrl_bench;

  localparam time TCK = 8ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_we;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        ack;
  logic [31:0] rdata;
  logic [15:0] cfg_size;
  logic [23:0] cfg_wait;
  logic [7:0]  ext_cs_n;
  logic        ext_rd_n;
  logic [3:0]  ext_we_n;
  logic [25:0] ext_addr;
  logic [31:0] ext_dout, ext_din;

  int n_cmp = 0;
  int n_bad = 0;

  always #(TCK/2) clk = ~clk;

  xbus_area_ctrl u_xbus_area_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .cfg_size(cfg_size), .cfg_wait(cfg_wait), .ext_cs_n(ext_cs_n),
    .ext_rd_n(ext_rd_n), .ext_we_n(ext_we_n), .ext_addr(ext_addr),
    .ext_dout(ext_dout), .ext_din(ext_din)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int bytes_of(input logic [1:0] code);
    if (code == 2'b01) return 1;
    if (code == 2'b10) return 2;
    return 4;
  endfunction

  function automatic int wait_of(input int area, input logic [2:0] code);
    if (area != 4) return int'(code[1:0]);
    case (code)
      3'd5:    return 6;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return int'(code);
    endcase
  endfunction

  function automatic logic [31:0] din_fn(input logic [25:0] a);
    return ({6'd0, a} * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  task automatic set_area(input int area, input logic [1:0] sz, input logic [2:0] wc);
    cfg_size[area*2 +: 2] = sz;
    cfg_wait[area*3 +: 3] = wc;
  endtask

  task automatic xfer(input bit we, input logic [31:0] addr, input logic [1:0] sz,
                      input logic [31:0] wd, input string tag);
    int area, pb, ab, ub, nb, nw, per, total;
    logic [31:0] acc;
    area  = int'(addr[28:26]);
    pb    = bytes_of(cfg_size[area*2 +: 2]);
    ab    = bytes_of(sz);
    ub    = (ab < pb) ? ab : pb;
    nb    = ab / ub;
    nw    = wait_of(area, cfg_wait[area*3 +: 3]);
    per   = nw + 3;
    total = nb * per;
    acc   = '0;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = addr; req_size = sz; req_wdata = wd;
    for (int c = 0; c < total; c++) begin
      int beat, ph, baddr, lo;
      logic [31:0] um, dv, exp_chunk;
      logic [7:0]  ecs;
      logic [3:0]  ewe;
      bit stb;
      string tstb, tlane;
      @(negedge clk);
      beat  = c / per;
      ph    = c % per;
      baddr = int'(addr[25:0]) + beat * ub;
      lo    = pb - (baddr % pb) - ub;
      um    = (ub == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*ub)) - 32'd1);
      stb   = (ph >= 1) && (ph <= nw + 1);
      tstb  = !stb ? "R4" : (area == 4) ? "R7" : "R6";
      tlane = (pb == 4) ? "R9" : "R10";
      ecs   = ~(8'd1 << area);
      check(ext_cs_n == ecs, "R1", "chip select", 64'(ext_cs_n), 64'(ecs));
      check($countones(~ext_cs_n) <= 1, "R3", "select count",
            64'($countones(~ext_cs_n)), 64'd1);
      check(ext_rd_n == !(stb && !we), tstb, "read strobe",
            64'(ext_rd_n), 64'(!(stb && !we)));
      ewe = (stb && we) ? ~(4'((1 << ub) - 1) << lo) : 4'hF;
      check(ext_we_n == ewe, tlane, "write strobes", 64'(ext_we_n), 64'(ewe));
      check(ext_addr == 26'(baddr), "R11", "beat address", 64'(ext_addr), 64'(baddr));
      if (stb && we) begin
        exp_chunk = (wd >> (8*ub*(nb-1-beat))) & um;
        check(((ext_dout >> (8*lo)) & um) == exp_chunk, tlane, "write lanes",
              64'((ext_dout >> (8*lo)) & um), 64'(exp_chunk));
      end
      check(ack == (c == total - 1), "R5", "ack timing", 64'(ack), 64'(c == total - 1));
      dv = din_fn(26'(baddr));
      ext_din = dv;
      if (!we && ph == nw + 1) acc = (acc << (8*ub)) | ((dv >> (8*lo)) & um);
      if (c == total - 1) begin
        if (!we) check(rdata == acc, tag, "read data", 64'(rdata), 64'(acc));
        req = 1'b0;
      end
    end
    @(negedge clk);
    check((&ext_cs_n) && ext_rd_n && (&ext_we_n) && !ack, "R4", "release after ack",
          64'({ext_cs_n, ext_rd_n, ext_we_n, ack}), 64'({8'hFF, 1'b1, 4'hF, 1'b0}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_size = '0;
    req_wdata = '0; cfg_size = '0; cfg_wait = '0; ext_din = '0;
    repeat (3) @(negedge clk);
    check((&ext_cs_n) && ext_rd_n && (&ext_we_n) && !ack, "R2", "in reset",
          64'({ext_cs_n, ext_rd_n, ext_we_n, ack}), 64'({8'hFF, 1'b1, 4'hF, 1'b0}));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check((&ext_cs_n) && ext_rd_n && (&ext_we_n) && !ack, "R2", "idle after reset",
          64'({ext_cs_n, ext_rd_n, ext_we_n, ack}), 64'({8'hFF, 1'b1, 4'hF, 1'b0}));

    // Area 3, longword port, 3 waits; then bit 2 of the field set (R6).
    set_area(3, 2'b11, 3'd3);
    xfer(1'b1, 32'h0C00_0100, 2'b11, 32'h1122_3344, "R1");
    xfer(1'b0, 32'h0C00_0104, 2'b11, 32'h0, "R5");
    set_area(3, 2'b11, 3'd6);
    xfer(1'b0, 32'h0C00_0200, 2'b11, 32'h0, "R6");
    // Shadow copy of area 3 (R1).
    xfer(1'b0, 32'hAC00_0010, 2'b11, 32'h0, "R1");
    xfer(1'b1, 32'hEC00_0020, 2'b10, 32'h0000_BEEF, "R1");

    // Area 4 every wait code (R7).
    for (int k = 0; k < 8; k++) begin
      set_area(4, 2'b11, 3'(k));
      xfer(1'b0, 32'h1000_0040, 2'b11, 32'h0, "R7");
    end

    // Byte and word lanes on a 32-bit port (R9).
    set_area(5, 2'b11, 3'd1);
    for (int o = 0; o < 4; o++)
      xfer(1'b1, 32'h1400_0000 + 32'(o), 2'b01, 32'h0000_00A0 + 32'(o), "R9");
    xfer(1'b1, 32'h1400_0000, 2'b10, 32'h0000_CAFE, "R9");
    xfer(1'b1, 32'h1400_0002, 2'b10, 32'h0000_F00D, "R9");
    xfer(1'b0, 32'h1400_0003, 2'b01, 32'h0, "R9");
    xfer(1'b0, 32'h1400_0002, 2'b10, 32'h0, "R9");

    // Narrow ports and splitting (R10).
    set_area(1, 2'b01, 3'd2);
    xfer(1'b1, 32'h0400_0010, 2'b11, 32'hDEAD_BEEF, "R10");
    xfer(1'b0, 32'h0400_0014, 2'b11, 32'h0, "R10");
    xfer(1'b0, 32'h0400_0016, 2'b10, 32'h0, "R10");
    set_area(2, 2'b10, 3'd0);
    xfer(1'b1, 32'h0800_0008, 2'b11, 32'h0102_0304, "R10");
    xfer(1'b0, 32'h0800_0009, 2'b01, 32'h0, "R10");
    xfer(1'b0, 32'h0800_000C, 2'b11, 32'h0, "R10");

    // Reserved size code 00 on both sides means longword (R8).
    set_area(6, 2'b00, 3'd1);
    xfer(1'b0, 32'h1800_0004, 2'b00, 32'h0, "R8");
    xfer(1'b1, 32'h1800_0008, 2'b00, 32'h7654_3210, "R8");
    set_area(7, 2'b10, 3'd0);
    xfer(1'b0, 32'h1C00_0000, 2'b00, 32'h0, "R8");

    // Constrained random mix.
    for (int i = 0; i < 400; i++) begin
      int area, ab;
      logic [1:0]  sz;
      logic [31:0] addr;
      area = int'($urandom % 8);
      set_area(area, 2'($urandom), 3'($urandom));
      sz   = 2'($urandom);
      ab   = bytes_of(sz);
      addr = {3'($urandom), 3'(area), 26'($urandom)};
      addr = addr & ~(32'(ab) - 32'd1);
      xfer(1'($urandom), addr, sz, $urandom, "R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule